// File: doc/BRIEF.md
# Buffered Triangle-Wave PWM Timer

This block is one channel of a pulse-width modulation timer. Its counter advances on a count-enable tick that an outside prescaler supplies. The counter can run as a sawtooth, counting either up or down, or as a triangle that climbs to the period value and then falls back to zero. Two compare/capture registers set the PWM edge and the point where the analog-to-digital converter (ADC) starts. Each of them has a shadow buffer register.

When buffering is on, the contents of each buffer move into its compare register at the top turning point, at the bottom turning point, or at both. If software loads a different value before each turning point, the rising and falling halves of a triangle period use different thresholds, and the pulse is no longer centred. When buffering is off, buffer register 0 sets a second PWM edge, so the raw pulse becomes a window, and buffer register 1 sets a second ADC trigger point.

The raw pulse drives a complementary output pair. A programmable dead band keeps both outputs low while one side hands over to the other. The channel also produces single-cycle wrap pulses at the top and at the bottom of the count. Start, stop and clear triggers control the counter. Each compare register can instead latch the count when its capture input sees a rising edge.

Top module: `pwm_tri_timer`

## Requirements
- R1: Control field ctrl[1:0] (ctrl is at address 0, the period register at address 1) selects the sawtooth modes. With value 0, each enabled tick adds one to the count, and the tick that finds the count at or above the period sets it to 0. With value 1, each enabled tick subtracts one, and the tick that finds the count at 0 reloads it with the period.
- R2: With ctrl[1:0] = 2 the counter runs as a triangle. It rises to the period value, turns, and falls to 0, then turns again. It takes the period value and the value 0 for exactly one tick at each turn.
- R3: Output ovf_irq is a one-cycle pulse in the cycle after the tick that leaves the top of the count (the up wrap or the triangle crest). Output udf_irq is a one-cycle pulse after the tick that leaves the bottom (the down reload or the triangle trough). The two pulses never occur together.
- R4: With ctrl[2] = 1, the buffers (addresses 4 and 5) are copied into the compare registers (addresses 2 and 3) when the count leaves the top, if ctrl[3] = 1, and when it leaves the bottom, if ctrl[4] = 1. Otherwise a compare register changes only through a direct write or a capture. When more than one applies in the same cycle, capture comes first, then the direct write, then the transfer.
- R5: The raw PWM level depends on buffering. With buffering on, it is high while count < compare 0. With buffering off, it is high while compare 0 <= count < buffer 0. With a dead time of 0, pwm_hi equals the raw level one clock later, and pwm_lo is its inverse.
- R6: The dead time D is held in the low DT_W bits at address 6. When the raw level changes and D > 0, both outputs go low for D clocks, and then the side that matches the new level goes high. pwm_hi and pwm_lo are never high at the same time.
- R7: Bit ctrl[5] puts channel 0 in capture mode, and ctrl[6] does the same for channel 1. In capture mode, a rising edge on cap_in[i] latches the current count into compare register i. The edge passes a two-flop synchroniser first when SYNC_CAP = 1.
- R8: trig_clear sets the count to 0 (to the period value in down mode) and resets the direction to up; a tick in the same cycle is lost. trig_stop takes priority over trig_start. Ticks are counted only while the counter is running, starting with the clock after the one that sampled the start.
- R9: adc_trig is high for the one cycle after a tick that lands the count on compare 1. With buffering off, a tick that lands the count on buffer 1 also raises it.
- R10: Reset sets the count, all registers, both PWM outputs and all pulses to 0. Writes to address 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| tick | input | 1 | Count enable from the prescaler |
| trig_start | input | 1 | Start trigger |
| trig_stop | input | 1 | Stop trigger |
| trig_clear | input | 1 | Clear trigger |
| cap_in | input | 2 | Capture inputs, one per channel |
| count | output | CNT_W | Current counter value |
| cc0_val | output | CNT_W | Compare/capture register 0 |
| cc1_val | output | CNT_W | Compare/capture register 1 |
| pwm_hi | output | 1 | High-side PWM output |
| pwm_lo | output | 1 | Complementary low-side PWM output |
| ovf_irq | output | 1 | Top-of-count pulse |
| udf_irq | output | 1 | Bottom-of-count pulse |
| adc_trig | output | 1 | ADC conversion start pulse |

## Verification
The bench instantiates the block with CNT_W = 8, DT_W = 4 and SYNC_CAP = 1. The 8-bit count keeps random periods short, so every run passes through many crests, troughs and buffer transfers. It also lets compare values land on 0, on the period and above it, which drives the pulse to always off and always on. The 4-bit dead time covers values from 0 up to longer than some pulse halves, so raw changes that restart the dead band are reached. Building with the synchroniser on exercises the longer capture path.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

   typedef enum logic [1:0] {
      CM_UP   = 2'd0,
      CM_DOWN = 2'd1,
      CM_TRI  = 2'd2,
      CM_RSV  = 2'd3
   } cnt_mode_e;

   typedef struct packed {
      logic [1:0] cap_en;
      logic       xfer_bot;
      logic       xfer_top;
      logic       buf_en;
      cnt_mode_e  mode;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_PERIOD = 3'd1;
   localparam logic [2:0] A_CC0    = 3'd2;
   localparam logic [2:0] A_BUF0   = 3'd4;
   localparam logic [2:0] A_DEAD   = 3'd6;

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
   import pwmt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_mode_e        mode,
   input  logic [CNT_W-1:0] period,
   input  logic             tick,
   input  logic             trig_start,
   input  logic             trig_stop,
   input  logic             trig_clear,
   output logic [CNT_W-1:0] cnt,
   output logic             top_ev,
   output logic             bot_ev,
   output logic             ovf_irq,
   output logic             udf_irq,
   output logic             stepped
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             run_q;
   logic             dir_dn_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             dir_nx;
   logic             at_top;
   logic             at_bot;
   logic             adv;

   assign adv = run_q & tick & ~trig_clear;

   always_comb begin
      cnt_nx = cnt_q;
      dir_nx = dir_dn_q;
      at_top = 1'b0;
      at_bot = 1'b0;
      case (mode)
         CM_DOWN: begin
            if (cnt_q == '0) begin
               cnt_nx = period;
               at_bot = 1'b1;
            end else begin
               cnt_nx = cnt_q - ONE;
            end
         end
         CM_TRI: begin
            if (!dir_dn_q) begin
               if (cnt_q >= period) begin
                  dir_nx = 1'b1;
                  at_top = 1'b1;
                  cnt_nx = (cnt_q == '0) ? '0 : cnt_q - ONE;
               end else begin
                  cnt_nx = cnt_q + ONE;
               end
            end else begin
               if (cnt_q == '0) begin
                  dir_nx = 1'b0;
                  at_bot = 1'b1;
                  cnt_nx = (period == '0) ? '0 : ONE;
               end else begin
                  cnt_nx = cnt_q - ONE;
               end
            end
         end
         default: begin
            if (cnt_q >= period) begin
               cnt_nx = '0;
               at_top = 1'b1;
            end else begin
               cnt_nx = cnt_q + ONE;
            end
         end
      endcase
   end

   assign top_ev = adv & at_top;
   assign bot_ev = adv & at_bot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         dir_dn_q <= 1'b0;
         cnt_q    <= '0;
         ovf_irq  <= 1'b0;
         udf_irq  <= 1'b0;
         stepped  <= 1'b0;
      end else begin
         if (trig_stop)
            run_q <= 1'b0;
         else if (trig_start)
            run_q <= 1'b1;
         if (trig_clear) begin
            cnt_q    <= (mode == CM_DOWN) ? period : '0;
            dir_dn_q <= 1'b0;
         end else if (adv) begin
            cnt_q    <= cnt_nx;
            dir_dn_q <= dir_nx;
         end
         ovf_irq <= top_ev;
         udf_irq <= bot_ev;
         stepped <= adv;
      end
   end

   assign cnt = cnt_q;

   // R1
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && !trig_clear && mode == CM_UP && cnt_q < period)
      |=> (cnt_q == $past(cnt_q) + ONE));

   // R2
   crest_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CM_TRI && top_ev) |=> dir_dn_q);

   // R3
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_irq && udf_irq));

   // R3
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_irq || udf_irq) |-> $past(run_q && tick));

endmodule

// File: rtl/pwmt_cc_bank.sv
module pwmt_cc_bank
   import pwmt_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SYNC_CAP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2:0]            wr_addr,
   input  logic [CNT_W-1:0]      wr_data,
   input  logic                  buf_en,
   input  logic                  xfer_top,
   input  logic                  xfer_bot,
   input  logic [1:0]            cap_en,
   input  logic                  top_ev,
   input  logic                  bot_ev,
   input  logic [CNT_W-1:0]      cnt,
   input  logic [1:0]            cap_in,
   output logic [1:0][CNT_W-1:0] cc_val,
   output logic [1:0][CNT_W-1:0] bf_val
);

   localparam int unsigned N_CH = 2;

   logic xfer_now;
   assign xfer_now = buf_en & ((top_ev & xfer_top) | (bot_ev & xfer_bot));

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic rise;
      logic cc_hit;
      logic bf_hit;

      if (SYNC_CAP) begin : g_sync
         logic s1_q;
         logic s2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1_q <= 1'b0;
               s2_q <= 1'b0;
            end else begin
               s1_q <= cap_in[g];
               s2_q <= s1_q;
            end
         end
         assign rise = s1_q & ~s2_q;
      end else begin : g_direct
         logic d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) d_q <= 1'b0;
            else        d_q <= cap_in[g];
         end
         assign rise = cap_in[g] & ~d_q;
      end

      assign cc_hit = wr_en && (wr_addr == (A_CC0 + 3'(g)));
      assign bf_hit = wr_en && (wr_addr == (A_BUF0 + 3'(g)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cc_val[g] <= '0;
            bf_val[g] <= '0;
         end else begin
            if (cap_en[g] && rise)
               cc_val[g] <= cnt;
            else if (cc_hit)
               cc_val[g] <= wr_data;
            else if (xfer_now && !cap_en[g])
               cc_val[g] <= bf_val[g];
            if (bf_hit)
               bf_val[g] <= wr_data;
         end
      end

      // R7
      cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_en[g] && rise) |=> (cc_val[g] == $past(cnt)));

      // R4
      cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!(cap_en[g] && rise) && !cc_hit && !xfer_now) |=> $stable(cc_val[g]));
   end

endmodule

// File: rtl/pwmt_deadband.sv
module pwmt_deadband #(
   parameter int unsigned DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw,
   input  logic [DT_W-1:0] dead,
   output logic            out_hi,
   output logic            out_lo
);

   localparam logic [DT_W-1:0] ONE = DT_W'(1);

   logic            rq;
   logic [DT_W-1:0] dt_q;
   logic            changed;

   assign changed = (raw != rq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rq     <= 1'b0;
         dt_q   <= '0;
         out_hi <= 1'b0;
         out_lo <= 1'b0;
      end else if (changed) begin
         rq   <= raw;
         dt_q <= dead;
         if (dead == '0) begin
            out_hi <= raw;
            out_lo <= ~raw;
         end else begin
            out_hi <= 1'b0;
            out_lo <= 1'b0;
         end
      end else if (dt_q != '0) begin
         dt_q <= dt_q - ONE;
         if (dt_q == ONE) begin
            out_hi <= rq;
            out_lo <= ~rq;
         end
      end else begin
         out_hi <= rq;
         out_lo <= ~rq;
      end
   end

   // R6
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_hi && out_lo));

   // R6
   gap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (changed && dead != '0) |=> (!out_hi && !out_lo));

endmodule

// File: rtl/pwm_tri_timer.sv
module pwm_tri_timer
   import pwmt_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned DT_W     = 8,
   parameter bit          SYNC_CAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   input  logic             trig_start,
   input  logic             trig_stop,
   input  logic             trig_clear,
   input  logic [1:0]       cap_in,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cc0_val,
   output logic [CNT_W-1:0] cc1_val,
   output logic             pwm_hi,
   output logic             pwm_lo,
   output logic             ovf_irq,
   output logic             udf_irq,
   output logic             adc_trig
);

   initial begin
      width_range_chk: assert (CNT_W >= CTRL_W && CNT_W <= 32)
         else $error("CNT_W must lie between %0d and 32", CTRL_W);
      dead_range_chk: assert (DT_W >= 1 && DT_W <= CNT_W)
         else $error("DT_W must lie between 1 and CNT_W");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] period_q;
   logic [DT_W-1:0]  dead_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
         dead_q   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL:   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
            A_PERIOD: period_q <= wr_data;
            A_DEAD:   dead_q   <= wr_data[DT_W-1:0];
            default:  ;
         endcase
      end
   end

   logic [CNT_W-1:0]      cnt;
   logic                  top_ev;
   logic                  bot_ev;
   logic                  stepped;
   logic [1:0][CNT_W-1:0] cc_val;
   logic [1:0][CNT_W-1:0] bf_val;
   logic                  raw;

   pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (ctrl_q.mode),
      .period     (period_q),
      .tick       (tick),
      .trig_start (trig_start),
      .trig_stop  (trig_stop),
      .trig_clear (trig_clear),
      .cnt        (cnt),
      .top_ev     (top_ev),
      .bot_ev     (bot_ev),
      .ovf_irq    (ovf_irq),
      .udf_irq    (udf_irq),
      .stepped    (stepped)
   );

   pwmt_cc_bank #(.CNT_W(CNT_W), .SYNC_CAP(SYNC_CAP)) u_cc (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .buf_en   (ctrl_q.buf_en),
      .xfer_top (ctrl_q.xfer_top),
      .xfer_bot (ctrl_q.xfer_bot),
      .cap_en   (ctrl_q.cap_en),
      .top_ev   (top_ev),
      .bot_ev   (bot_ev),
      .cnt      (cnt),
      .cap_in   (cap_in),
      .cc_val   (cc_val),
      .bf_val   (bf_val)
   );

   assign raw = ctrl_q.buf_en ? (cnt < cc_val[0])
                              : ((cnt >= cc_val[0]) && (cnt < bf_val[0]));

   pwmt_deadband #(.DT_W(DT_W)) u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw),
      .dead   (dead_q),
      .out_hi (pwm_hi),
      .out_lo (pwm_lo)
   );

   assign adc_trig = stepped &
                     ((cnt == cc_val[1]) | (~ctrl_q.buf_en & (cnt == bf_val[1])));

   assign count   = cnt;
   assign cc0_val = cc_val[0];
   assign cc1_val = cc_val[1];

   // R9
   adc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> $past(tick));

endmodule

// File: tb/pwm_tri_timer_tb_top.sv
module pwm_tri_timer_tb_top;

   localparam int W  = 8;
   localparam int DW = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         tick = 1'b0;
   logic         trig_start = 1'b0;
   logic         trig_stop = 1'b0;
   logic         trig_clear = 1'b0;
   logic [1:0]   cap_in = '0;
   logic [W-1:0] count, cc0_val, cc1_val;
   logic         pwm_hi, pwm_lo, ovf_irq, udf_irq, adc_trig;

   always #10 clk = ~clk;

   pwm_tri_timer #(.CNT_W(W), .DT_W(DW), .SYNC_CAP(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .trig_start(trig_start),
      .trig_stop(trig_stop), .trig_clear(trig_clear), .cap_in(cap_in),
      .count(count), .cc0_val(cc0_val), .cc1_val(cc1_val),
      .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .ovf_irq(ovf_irq),
      .udf_irq(udf_irq), .adc_trig(adc_trig)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // reference model state
   int m_mode = 0, m_per = 0, m_dead = 0;
   bit m_buf = 0, m_xt = 0, m_xb = 0;
   bit [1:0] m_cap = 0;
   bit m_run = 0, m_dir = 0, m_ovf = 0, m_udf = 0, m_step = 0;
   int m_cnt = 0;
   int m_cc [2] = '{0, 0};
   int m_bf [2] = '{0, 0};
   bit [1:0] m_s1 = 0, m_s2 = 0;
   bit m_rq = 0, m_hi = 0, m_lo = 0;
   int m_dt = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit f_raw();
      if (m_buf) return (m_cnt < m_cc[0]);
      return (m_cnt >= m_cc[0]) && (m_cnt < m_bf[0]);
   endfunction

   task automatic compare_all();
      chk((m_mode == 2) ? "R2 count" : "R1 count", count, m_cnt);
      chk("R3 ovf", ovf_irq, m_ovf);
      chk("R3 udf", udf_irq, m_udf);
      chk("R4 cc0", cc0_val, m_cc[0]);
      chk("R4 cc1", cc1_val, m_cc[1]);
      chk((m_dead == 0) ? "R5 hi" : "R6 hi", pwm_hi, m_hi);
      chk((m_dead == 0) ? "R5 lo" : "R6 lo", pwm_lo, m_lo);
      chk("R6 overlap", pwm_hi & pwm_lo, 0);
      chk("R9 adc", adc_trig,
          m_step & ((m_cnt == m_cc[1]) | (!m_buf & (m_cnt == m_bf[1]))));
   endtask

   // one clock: model follows the requirements using pre-edge values
   task automatic cyc();
      bit raw, adv, cr, tr, nd;
      int n;
      bit [1:0] rise;
      @(posedge clk);
      raw = f_raw();
      adv = m_run & tick & ~trig_clear;
      cr = 0; tr = 0; nd = m_dir; n = m_cnt;
      case (m_mode)
         1: if (m_cnt == 0) begin n = m_per; tr = 1; end else n = m_cnt - 1;
         2: if (!m_dir) begin
               if (m_cnt >= m_per) begin nd = 1; cr = 1; n = (m_cnt == 0) ? 0 : m_cnt - 1; end
               else n = m_cnt + 1;
            end else begin
               if (m_cnt == 0) begin nd = 0; tr = 1; n = (m_per == 0) ? 0 : 1; end
               else n = m_cnt - 1;
            end
         default: if (m_cnt >= m_per) begin n = 0; cr = 1; end else n = m_cnt + 1;
      endcase
      rise = m_s1 & ~m_s2;
      for (int g = 0; g < 2; g++) begin
         if (m_cap[g] && rise[g]) m_cc[g] = m_cnt;
         else if (wr_en && wr_addr == 3'(2 + g)) m_cc[g] = wr_data;
         else if (m_buf && !m_cap[g] && adv && ((cr && m_xt) || (tr && m_xb)))
            m_cc[g] = m_bf[g];
      end
      for (int g = 0; g < 2; g++)
         if (wr_en && wr_addr == 3'(4 + g)) m_bf[g] = wr_data;
      if (raw != m_rq) begin
         m_rq = raw; m_dt = m_dead;
         if (m_dead == 0) begin m_hi = raw; m_lo = !raw; end
         else begin m_hi = 0; m_lo = 0; end
      end else if (m_dt != 0) begin
         if (m_dt == 1) begin m_hi = m_rq; m_lo = !m_rq; end
         m_dt--;
      end else begin
         m_hi = m_rq; m_lo = !m_rq;
      end
      m_s2 = m_s1; m_s1 = cap_in;
      if (trig_clear) begin
         m_cnt = (m_mode == 1) ? m_per : 0; m_dir = 0;
      end else if (adv) begin
         m_cnt = n; m_dir = nd;
      end
      m_ovf = adv & cr; m_udf = adv & tr; m_step = adv;
      if (trig_stop) m_run = 0; else if (trig_start) m_run = 1;
      if (wr_en) begin
         case (wr_addr)
            3'd0: begin
               m_mode = wr_data[1:0]; m_buf = wr_data[2]; m_xt = wr_data[3];
               m_xb = wr_data[4]; m_cap = wr_data[6:5];
            end
            3'd1: m_per = wr_data;
            3'd6: m_dead = wr_data[DW-1:0];
            default: ;
         endcase
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1; wr_addr = 3'(a); wr_data = W'(d);
      cyc();
      wr_en = 0;
   endtask

   task automatic pulse_start();
      trig_start = 1; cyc(); trig_start = 0;
   endtask

   task automatic pulse_clear();
      trig_clear = 1; cyc(); trig_clear = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      int gap, adc_n;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 count", count, 0);
      chk("R10 hi", pwm_hi, 0);
      chk("R10 lo", pwm_lo, 0);
      chk("R10 ovf", ovf_irq | udf_irq | adc_trig, 0);
      chk("R10 cc", cc0_val | cc1_val, 0);
      rst_n = 1;
      cyc();

      // R8 ticks ignored while stopped; R10 address 7 ignored
      wr(1, 5);
      wr(7, 8'hff);
      tick = 1;
      repeat (4) cyc();
      chk("R8 idle count", count, 0);
      pulse_start();
      repeat (3) cyc();
      chk("R8 running count", count, 3);
      trig_clear = 1; cyc(); trig_clear = 0;
      chk("R8 clear wins", count, 0);
      trig_start = 1; trig_stop = 1; cyc(); trig_start = 0; trig_stop = 0;
      repeat (3) cyc();
      chk("R8 stop wins", count, 1);
      tick = 0;

      // random runs in all three modes
      for (int it = 0; it < 24; it++) begin
         int per, md;
         md  = it % 3;
         per = 3 + $urandom % 20;
         wr(0, md | (($urandom % 2) << 2) | (($urandom % 4) << 3));
         wr(1, per);
         wr(2, $urandom % (per + 2));
         wr(3, $urandom % (per + 1));
         wr(4, $urandom % (per + 2));
         wr(5, $urandom % (per + 1));
         wr(6, $urandom % 6);
         pulse_clear();
         pulse_start();
         for (int k = 0; k < 6 * (per + 1); k++) begin
            tick = ($urandom % 4) != 0;
            if ($urandom % 8 == 0) begin
               wr_en = 1; wr_addr = 3'(4 + $urandom % 2); wr_data = W'($urandom % (per + 2));
            end
            cyc();
            wr_en = 0;
         end
         tick = 0;
      end

      // R2 R4 asymmetric triangle: buffer reloaded before each turn
      wr(0, 2 | (1 << 2) | (1 << 3) | (1 << 4));
      wr(1, 12); wr(2, 4); wr(4, 4); wr(6, 0);
      pulse_clear(); pulse_start();
      tick = 1;
      for (int k = 0; k < 4; k++) begin
         while (!(ovf_irq | udf_irq)) cyc();
         wr(4, ovf_irq ? 9 : 3);
      end
      repeat (30) cyc();

      // R6 explicit dead gap in up mode
      wr(0, 0 | (1 << 2)); wr(1, 15); wr(2, 8); wr(6, 3);
      pulse_clear();
      gap = 0;
      while (!pwm_hi && gap < 60) begin gap++; cyc(); end
      while (pwm_hi) cyc();
      gap = 0;
      while (!pwm_lo && gap < 60) begin gap++; cyc(); end
      chk("R6 gap", gap, 3);

      // R9 one ADC pulse per up period
      wr(3, 5); pulse_clear();
      adc_n = 0;
      for (int k = 0; k < 16; k++) begin cyc(); adc_n += adc_trig; end
      chk("R9 adc per period", adc_n, 1);

      // R5 unbuffered window
      wr(0, 0); wr(2, 4); wr(4, 10); wr(6, 0);
      repeat (40) cyc();

      // R7 capture on both channels with counter frozen
      trig_stop = 1; cyc(); trig_stop = 0;
      wr(0, 3 << 5);
      cap_in = 2'b01; repeat (3) cyc();
      chk("R7 capture ch0", cc0_val, count);
      cap_in = 2'b11; repeat (3) cyc();
      chk("R7 capture ch1", cc1_val, count);
      cap_in = 2'b00; pulse_start();
      repeat (5) cyc();
      cap_in = 2'b10; repeat (4) cyc();
      cap_in = 2'b00; repeat (4) cyc();
      tick = 0;

      // R1 down mode reload
      wr(0, 1); wr(1, 6); pulse_clear();
      chk("R1 down clear", count, 6);
      tick = 1;
      repeat (20) cyc();
      tick = 0;

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule